// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

This block takes a wide vector of GPIO pad inputs and routes any eight of them onto eight interrupt lines for a downstream interrupt controller. Each line has its own pad-select field and its own trigger setup. The block conditions the chosen pad so that every output is active-high. In level mode the output is a level that stays high while the condition holds. In edge mode the output is a one-cycle pulse on each qualifying transition. Software picks level or edge sensing, inversion, and a both-edge mode, which takes priority over the other two.

The chosen pad passes through a two-stage synchroniser. An optional per-line glitch filter then requires the synchronised value to stay steady for a programmable number of cycles before the filtered value follows it. A plain word-addressed write/read port holds all settings. Writing a line's settings restarts that line's edge history and mutes its pulses for a short window. A change of pad or trigger type therefore cannot produce a false interrupt.

Top module: `gpr_router`

## Requirements
- R1: After reset every register reads zero. Every line then selects pad 0 in active-high level mode with no filter, so each output follows pad 0.
- R2: The register file has four words. Word 0 holds trigger bits: bit n = edge mode for line n, bit 8+n = both-edge for line n, bit 16+n = active-low for line n. Word 1 holds the selects of lines 0-3 and word 2 the selects of lines 4-7, with line n at bits (n mod 4)*8 and up. Word 3 holds a 4-bit filter code for line n at bits n*4 and up. Reads return the stored bits. Bits 24-31 of word 0 and select bits at or above the pad-index width read as zero.
- R3: Writes to word indices 4 and above change nothing, and reads there return zero.
- R4: In level mode with no filter, line n outputs the pad chosen by its select field. A pad change sampled at a rising edge appears at the output after the second rising edge. A select value at or beyond the pad count reads as a low pad.
- R5: In level mode with the active-low bit set, the output is the inverse of the pad.
- R6: In edge mode with the active-low bit clear, the output is high for exactly one cycle after each rising pad transition, and falling transitions give nothing.
- R7: In edge mode with the active-low bit set, the output pulses for one cycle on each falling pad transition only.
- R8: With the both-edge bit set, the output pulses for one cycle on every pad transition, whatever the edge and active-low bits say.
- R9: A nonzero filter code k makes the filtered value follow the synchronised pad only after 2*k consecutive cycles of disagreement. A pulse of 2*k-1 cycles is lost. A held change shows at the output 2+2*k rising edges after it is sampled. Code 0 bypasses the filter.
- R10: Any write to a word that holds a line's settings (word 0, word 3, or the select word that holds that line) suppresses that line's edge pulses for the next four cycles and reloads its filter and edge history. A reconfiguration therefore never yields a pulse on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pads_i | input | NUM_PADS | GPIO pad levels, asynchronous to clk |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word index of the register access |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 8 | Conditioned active-high interrupt lines |

## Verification
The bench builds the router with 16 pads, so each select field is 4 bits wide. That lets one sweep cover every pad on every line: it rotates the selects through all 16 offsets against a rotating pad pattern. The filter scale stays at 2 and the lines under test use code 3. The 5-cycle glitch that must be dropped and the 6-cycle hold that must pass then fit in a few dozen cycles, and a bypassed line runs beside the filtered lines in the same run. The 4-bit address reaches twelve unused word indices for the write-ignore and read-zero checks.

// File: rtl/gpr_pkg.sv
`timescale 1ns/1ps
package gpr_pkg;
  localparam int NUM_CH     = 8;
  localparam int REG_W      = 32;
  localparam int FCODE_W    = 4;
  localparam int SYNC_DEPTH = 2;
  // mute window after a configuration write: synchroniser depth + filter load + history load
  localparam int BLANK_CYC  = SYNC_DEPTH + 2;
  localparam int BLANK_W    = $clog2(BLANK_CYC + 1);
  // word indices of the register file
  localparam int W_TRIG  = 0;
  localparam int W_SELLO = 1;
  localparam int W_SELHI = 2;
  localparam int W_FILT  = 3;
  localparam int N_WORDS = 4;
endpackage

// File: rtl/gpr_regs.sv
`timescale 1ns/1ps
module gpr_regs
  import gpr_pkg::*;
#(
  parameter int SEL_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en_i,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic [REG_W-1:0]                     wdata_i,
  output logic [REG_W-1:0]                     rdata_o,
  output logic [NUM_CH-1:0]                    edge_o,
  output logic [NUM_CH-1:0]                    both_o,
  output logic [NUM_CH-1:0]                    low_o,
  output logic [NUM_CH-1:0][SEL_W-1:0]         sel_o,
  output logic [NUM_CH-1:0][FCODE_W-1:0]       fcode_o,
  output logic [NUM_CH-1:0]                    cfg_wr_o
);
  localparam int HALF = NUM_CH / 2;

  logic [NUM_CH-1:0]              edge_q, edge_d, both_q, both_d, low_q, low_d;
  logic [NUM_CH-1:0][SEL_W-1:0]   sel_q, sel_d;
  logic [NUM_CH-1:0][FCODE_W-1:0] fc_q, fc_d;
  logic hit_trig, hit_sello, hit_selhi, hit_filt;

  always_comb begin
    hit_trig  = wr_en_i && (int'(addr_i) == W_TRIG);
    hit_sello = wr_en_i && (int'(addr_i) == W_SELLO);
    hit_selhi = wr_en_i && (int'(addr_i) == W_SELHI);
    hit_filt  = wr_en_i && (int'(addr_i) == W_FILT);
  end

  // next state
  always_comb begin
    edge_d = edge_q;
    both_d = both_q;
    low_d  = low_q;
    sel_d  = sel_q;
    fc_d   = fc_q;
    if (hit_trig) begin
      edge_d = wdata_i[0 +: NUM_CH];
      both_d = wdata_i[8 +: NUM_CH];
      low_d  = wdata_i[16 +: NUM_CH];
    end
    for (int n = 0; n < NUM_CH; n++) begin
      if ((n < HALF && hit_sello) || (n >= HALF && hit_selhi))
        sel_d[n] = wdata_i[(n % HALF)*8 +: SEL_W];
      if (hit_filt)
        fc_d[n] = wdata_i[n*FCODE_W +: FCODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      both_q <= '0;
      low_q  <= '0;
      sel_q  <= '0;
      fc_q   <= '0;
    end else if (wr_en_i) begin
      edge_q <= edge_d;
      both_q <= both_d;
      low_q  <= low_d;
      sel_q  <= sel_d;
      fc_q   <= fc_d;
    end
  end

  // per-line write notification
  always_comb begin
    for (int n = 0; n < NUM_CH; n++)
      cfg_wr_o[n] = hit_trig || hit_filt ||
                    (n < HALF ? hit_sello : hit_selhi);
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    case (int'(addr_i))
      W_TRIG:  rdata_o = {8'h00, low_q, both_q, edge_q};
      W_SELLO: for (int n = 0; n < HALF; n++) rdata_o[n*8 +: 8] = 8'(sel_q[n]);
      W_SELHI: for (int n = 0; n < HALF; n++) rdata_o[n*8 +: 8] = 8'(sel_q[n+HALF]);
      W_FILT:  for (int n = 0; n < NUM_CH; n++) rdata_o[n*FCODE_W +: FCODE_W] = fc_q[n];
      default: rdata_o = '0;
    endcase
  end

  assign edge_o  = edge_q;
  assign both_o  = both_q;
  assign low_o   = low_q;
  assign sel_o   = sel_q;
  assign fcode_o = fc_q;

  a_r3_oor_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && int'(addr_i) >= N_WORDS) |=>
      ($stable(edge_q) && $stable(both_q) && $stable(low_q) &&
       $stable(sel_q) && $stable(fc_q)));
endmodule

// File: rtl/gpr_chan.sv
`timescale 1ns/1ps
module gpr_chan
  import gpr_pkg::*;
#(
  parameter int NUM_PADS   = 256,
  parameter int SEL_W      = 8,
  parameter int FILT_SCALE = 2,
  parameter int CNT_W      = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pads_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                edge_i,
  input  logic                both_i,
  input  logic                low_i,
  input  logic [FCODE_W-1:0]  fcode_i,
  input  logic                cfg_wr_i,
  output logic                irq_o
);
  logic               pad_in;
  logic               s1_q, s2_q;
  logic               hold_q, hold_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, lim_m1;
  logic               prev_q;
  logic [BLANK_W-1:0] blank_q, blank_d;
  logic               blanking, filt, bypass;
  logic               p_single, p_both;

  always_comb pad_in = (int'(sel_i) < NUM_PADS) ? pads_i[sel_i] : 1'b0;

  always_comb begin
    bypass   = (fcode_i == '0);
    blanking = (blank_q != '0);
    filt     = bypass ? s2_q : hold_q;
    lim_m1   = CNT_W'(int'(fcode_i) * FILT_SCALE - 1);
  end

  // next state: blanking window, filter
  always_comb begin
    blank_d = cfg_wr_i ? BLANK_W'(BLANK_CYC) :
              (blanking ? blank_q - 1'b1 : blank_q);
    hold_d  = hold_q;
    cnt_d   = '0;
    if (blanking || bypass) begin
      hold_d = s2_q;
    end else if (!cfg_wr_i && (s2_q != hold_q)) begin
      if (cnt_q == lim_m1) hold_d = s2_q;
      else                 cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      hold_q  <= 1'b0;
      cnt_q   <= '0;
      prev_q  <= 1'b0;
      blank_q <= '0;
    end else begin
      s1_q    <= pad_in;
      s2_q    <= s1_q;
      hold_q  <= hold_d;
      cnt_q   <= cnt_d;
      prev_q  <= filt;
      blank_q <= blank_d;
    end
  end

  // trigger conditioning
  always_comb begin
    p_single = low_i ? (prev_q & ~filt) : (filt & ~prev_q);
    p_both   = filt ^ prev_q;
    if (both_i)      irq_o = p_both & ~blanking;
    else if (edge_i) irq_o = p_single & ~blanking;
    else             irq_o = filt ^ low_i;
  end

  a_r4_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> (s2_q == $past(pad_in, 2)));

  a_r6_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && !both_i && irq_o && !cfg_wr_i) |=> !irq_o);

  a_r9_filter_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(fcode_i) * FILT_SCALE > 1) && !blanking && !cfg_wr_i &&
     (s2_q != hold_q) && (cnt_q == '0)) |=> $stable(hold_q));

  a_r10_quiet_after_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_i |=> (!(edge_i || both_i) || !irq_o));
endmodule

// File: rtl/gpr_router.sv
`timescale 1ns/1ps
module gpr_router
  import gpr_pkg::*;
#(
  parameter int NUM_PADS   = 256,
  parameter int ADDR_W     = 4,
  parameter int FILT_SCALE = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pads_i,
  input  logic                reg_wr_en_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic [7:0]          irq_o
);
  localparam int SEL_W = $clog2(NUM_PADS);
  localparam int CNT_W = $clog2(((1 << FCODE_W) - 1) * FILT_SCALE + 1);

  logic [NUM_CH-1:0]              edge_w, both_w, low_w, cfg_wr_w;
  logic [NUM_CH-1:0][SEL_W-1:0]   sel_w;
  logic [NUM_CH-1:0][FCODE_W-1:0] fc_w;

  gpr_regs #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (reg_wr_en_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .edge_o   (edge_w),
    .both_o   (both_w),
    .low_o    (low_w),
    .sel_o    (sel_w),
    .fcode_o  (fc_w),
    .cfg_wr_o (cfg_wr_w)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    gpr_chan #(
      .NUM_PADS  (NUM_PADS),
      .SEL_W     (SEL_W),
      .FILT_SCALE(FILT_SCALE),
      .CNT_W     (CNT_W)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .pads_i   (pads_i),
      .sel_i    (sel_w[n]),
      .edge_i   (edge_w[n]),
      .both_i   (both_w[n]),
      .low_i    (low_w[n]),
      .fcode_i  (fc_w[n]),
      .cfg_wr_i (cfg_wr_w[n]),
      .irq_o    (irq_o[n])
    );
  end
endmodule

// File: tb/tb_gpr_router.sv
`timescale 1ns/1ps
module tb_gpr_router;
  localparam int NP = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pads;
  logic          wr_en;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [7:0]    irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  gpr_router #(.NUM_PADS(NP), .ADDR_W(AW), .FILT_SCALE(2)) dut (
    .clk(clk), .rst_n(rst_n), .pads_i(pads), .reg_wr_en_i(wr_en),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = AW'(a);
    #1 d = rdata;
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  // pads[7:0] rise then fall; expect the given pulse vectors
  task automatic edge_case(input string tag, input logic [31:0] cfg,
                           input logic [7:0] rise_exp, input logic [7:0] fall_exp);
    pads = '0;
    wr(0, cfg);
    wait_n(6);
    pads[7:0] = 8'hFF;
    @(negedge clk); chk({tag, " quiet before"}, 32'(irq), 32'h0);
    @(negedge clk); chk({tag, " rise pulse"}, 32'(irq), 32'(rise_exp));
    @(negedge clk); chk({tag, " rise one cycle"}, 32'(irq), 32'h0);
    wait_n(3);
    pads[7:0] = 8'h00;
    @(negedge clk);
    @(negedge clk); chk({tag, " fall pulse"}, 32'(irq), 32'(fall_exp));
    @(negedge clk); chk({tag, " fall one cycle"}, 32'(irq), 32'h0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [15:0] pat;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    pads = 16'h0001;
    wait_n(3);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(a, d); chk($sformatf("R1 reset word %0d", a), d, 32'h0);
    end
    wait_n(2);
    chk("R1 all lines follow pad 0", 32'(irq), 32'hFF);
    pads = '0;
    wait_n(3);
    chk("R1 pad 0 low", 32'(irq), 32'h0);

    // R2: readback with unimplemented bits zero
    for (int a = 0; a < 4; a++) wr(a, 32'hFFFF_FFFF);
    rd(0, d); chk("R2 trig word mask", d, 32'h00FF_FFFF);
    rd(1, d); chk("R2 sel lo mask", d, 32'h0F0F_0F0F);
    rd(2, d); chk("R2 sel hi mask", d, 32'h0F0F_0F0F);
    rd(3, d); chk("R2 filter word", d, 32'hFFFF_FFFF);
    wr(0, 32'h12A5_5AC3); rd(0, d); chk("R2 trig pattern", d, 32'h00A5_5AC3);
    wr(1, 32'h0102_0304); rd(1, d); chk("R2 sel lo pattern", d, 32'h0102_0304);
    wr(2, 32'hF5E6_D7C8); rd(2, d); chk("R2 sel hi pattern", d, 32'h0506_0708);
    wr(3, 32'h1234_5678); rd(3, d); chk("R2 filter pattern", d, 32'h1234_5678);

    // R3: out-of-range words
    for (int a = 4; a < 16; a++) begin
      wr(a, 32'hDEAD_BEEF);
      rd(a, d); chk($sformatf("R3 read zero word %0d", a), d, 32'h0);
    end
    rd(0, d); chk("R3 trig kept", d, 32'h00A5_5AC3);
    rd(1, d); chk("R3 sel lo kept", d, 32'h0102_0304);
    rd(2, d); chk("R3 sel hi kept", d, 32'h0506_0708);
    rd(3, d); chk("R3 filter kept", d, 32'h1234_5678);

    // R4: sweep of every pad on every line, level mode, no filter
    wr(0, 32'h0); wr(3, 32'h0);
    for (int p = 0; p < NP; p++) begin
      logic [31:0] lo, hi;
      pat = (16'hA5C3 << p) | (16'hA5C3 >> (16 - p));
      pads = pat;
      for (int n = 0; n < 4; n++) begin
        lo[n*8 +: 8] = 8'((p + n) % NP);
        hi[n*8 +: 8] = 8'((p + n + 4) % NP);
      end
      wr(1, lo); wr(2, hi);
      wait_n(3);
      for (int n = 0; n < 8; n++)
        chk($sformatf("R4 sweep p=%0d line %0d", p, n), 32'(irq[n]), 32'(pat[(p + n) % NP]));
    end
    // R4: two-edge latency
    pads = '0; wr(1, 32'h0); wr(2, 32'h0); wait_n(3);
    pads[0] = 1'b1;
    @(negedge clk); chk("R4 latency after 1 edge", 32'(irq), 32'h0);
    @(negedge clk); chk("R4 latency after 2 edges", 32'(irq), 32'hFF);

    // line n selects pad n from here on
    pads = '0;
    wr(1, 32'h0302_0100); wr(2, 32'h0706_0504);

    // R5: active-low level
    wr(0, 32'h00FF_0000);
    wait_n(3);
    chk("R5 low level, pads low", 32'(irq), 32'hFF);
    pads[7:0] = 8'h5A;
    wait_n(2);
    chk("R5 low level, pattern", 32'(irq), 32'hA5);

    edge_case("R6 rising", 32'h0000_00FF, 8'hFF, 8'h00);
    edge_case("R7 falling", 32'h00FF_00FF, 8'h00, 8'hFF);
    edge_case("R8 both overrides", 32'h00FF_FFFF, 8'hFF, 8'hFF);
    edge_case("R8 both plain", 32'h0000_FF00, 8'hFF, 8'hFF);

    // R9: filter code 3 on lines 1-7, bypass on line 0
    pads = '0;
    wr(0, 32'h0); wr(3, 32'h3333_3330);
    wait_n(6);
    pads[7:0] = 8'hFF;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      chk($sformatf("R9 glitch of 5, cycle %0d", i), 32'(irq),
          ((i >= 2 && i <= 6) ? 32'h01 : 32'h00));
      if (i == 5) pads[7:0] = 8'h00;
    end
    wait_n(4);
    pads[7:0] = 8'hFF;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      chk($sformatf("R9 hold, cycle %0d", i), 32'(irq),
          32'((i >= 2 ? 8'h01 : 8'h00) | (i >= 8 ? 8'hFE : 8'h00)));
    end

    // R10: reconfiguration produces no pulse
    pads = 16'hFF00;
    wr(3, 32'h0); wr(0, 32'h0000_00FF);
    wait_n(6);
    wr(1, 32'h0B0A_0908); wr(2, 32'h0F0E_0D0C);
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R10 no pulse on reselect, cycle %0d", i), 32'(irq), 32'h0);
      @(negedge clk);
    end
    pads = '0;
    wr(0, 32'h0000_FF00);
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R10 no pulse on mode change, cycle %0d", i), 32'(irq), 32'h0);
      @(negedge clk);
    end
    pads = 16'hFF00;
    @(negedge clk);
    @(negedge clk); chk("R10 line live after reconfig", 32'(irq), 32'hFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule